// File: doc/BRIEF.md
# Subtask Base-Register Merge Unit

This unit lets one firmware routine serve several identical devices at once. A device presents a 2-bit subtask number, and the unit captures it on the cycle's first phase strobe. It then ORs the captured number into the two low-order selector bits of both the register-bank base and the memory base. Each subtask therefore addresses its own 16-location register region and its own pair of memory base registers. If a device drives only the high subtask bit, each subtask instead gets two register regions and four memory base registers.

Some operations skip the merge on the register-bank side. A change-base write produces an address without the subtask bits. A base readback returns the value with the subtask already merged in. While a debugger freeze signal is asserted, the register-bank base is left untouched, but the memory base merge carries on. When no device drives the subtask lines they read as zero, and both bases pass through unchanged. The register file, the memory and the subtask source sit outside this unit.

Top module: `subtask_base_merge`

## Requirements
- R1: On a rising clock edge with `t0_i` high, `subtask_i` is captured, and the outputs use the captured value from that edge onward.
- R2: On a rising clock edge with `t0_i` low, the captured subtask keeps its value, whatever `subtask_i` does.
- R3: For an ordinary access (`access_i` = 2'b00, or the reserved code 2'b11) with `freeze_i` low, `rm_base_o` equals `rbase_i` with subtask bit 1 ORed into bit RBW-3 and subtask bit 0 ORed into bit RBW-4. The other bits are unchanged.
- R4: A base readback (`access_i` = 2'b01) with `freeze_i` low returns the same merged value as R3.
- R5: A change-base write (`access_i` = 2'b10) gives `rm_base_o` = `rbase_i`, whatever the subtask and freeze values are.
- R6: While `freeze_i` is high, `rm_base_o` = `rbase_i` for every access code.
- R7: `mem_base_o` equals `mbase_i` with subtask bit 1 ORed into bit MBW-3 and subtask bit 0 ORed into bit MBW-4, independent of `access_i` and `freeze_i`.
- R8: After reset the captured subtask is zero, so both outputs equal their base inputs until the first capture.
- R9: With a captured subtask whose bit 0 is zero, `rm_base_o` bit RBW-4 and `mem_base_o` bit MBW-4 follow their inputs. This leaves a second register region and a second memory pair per subtask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t0_i | input | 1 | First-phase strobe; captures the subtask |
| subtask_i | input | 2 | Device-supplied subtask number (zero when undriven) |
| freeze_i | input | 1 | Debugger freeze; suppresses the register-bank merge |
| access_i | input | 2 | 00 ordinary, 01 base readback, 10 change-base write, 11 ordinary |
| rbase_i | input | RBW | Register-bank base selector |
| mbase_i | input | MBW | Memory base selector |
| rm_base_o | output | RBW | Effective register-bank base |
| mem_base_o | output | MBW | Effective memory base |

## Verification
Several events can fall in the same cycle: a subtask capture, a freeze, and a change-base write or base readback. The bench provokes these deliberately. It pulses `t0_i` together with a new `subtask_i` in the same cycle that freeze is raised or a change-base write is issued. It then checks that the memory base picks up the new subtask at the edge while the register-bank base stays raw. It also holds `t0_i` low while `subtask_i` toggles under a base readback, to show that the readback keeps the old merged value. A behavioural model compares both outputs against expected values on every cycle.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  localparam int ST_W = 2;

  typedef enum logic [1:0] {
    ACC_ORDINARY = 2'b00,
    ACC_READBACK = 2'b01,
    ACC_CHG_WR   = 2'b10,
    ACC_RSVD     = 2'b11
  } access_t;
endpackage

// File: rtl/sbm_capture.sv
module sbm_capture
  import sbm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_i,
  input  logic [ST_W-1:0] sub_i,
  output logic [ST_W-1:0] sub_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sub_q_o <= '0;
    else if (strobe_i) sub_q_o <= sub_i;
  end
endmodule

// File: rtl/sbm_rbase_path.sv
module sbm_rbase_path
  import sbm_pkg::*;
#(
  parameter int RBW = 4
) (
  input  logic [RBW-1:0]  base_i,
  input  logic [ST_W-1:0] sub_i,
  input  logic [1:0]      access_i,
  input  logic            freeze_i,
  output logic            merge_en_o,
  output logic [RBW-1:0]  eff_o
);
  localparam int LSB = RBW - 4;

  function automatic logic [RBW-1:0] or_field(input logic [RBW-1:0] b,
                                              input logic [ST_W-1:0] s);
    logic [RBW-1:0] f;
    f = '0;
    f[LSB +: ST_W] = s;
    return b | f;
  endfunction

  access_t acc;
  assign acc = access_t'(access_i);

  always_comb begin
    unique case (acc)
      ACC_CHG_WR:   merge_en_o = 1'b0;
      ACC_READBACK: merge_en_o = !freeze_i;
      default:      merge_en_o = !freeze_i;
    endcase
  end

  assign eff_o = merge_en_o ? or_field(base_i, sub_i) : base_i;
endmodule

// File: rtl/sbm_mbase_path.sv
module sbm_mbase_path
  import sbm_pkg::*;
#(
  parameter int MBW = 5
) (
  input  logic [MBW-1:0]  base_i,
  input  logic [ST_W-1:0] sub_i,
  output logic [MBW-1:0]  eff_o
);
  localparam int LSB = MBW - 4;

  function automatic logic [MBW-1:0] or_field(input logic [MBW-1:0] b,
                                              input logic [ST_W-1:0] s);
    logic [MBW-1:0] f;
    f = '0;
    f[LSB +: ST_W] = s;
    return b | f;
  endfunction

  assign eff_o = or_field(base_i, sub_i);
endmodule

// File: rtl/subtask_base_merge.sv
module subtask_base_merge
  import sbm_pkg::*;
#(
  parameter int RBW = 4,
  parameter int MBW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           t0_i,
  input  logic [1:0]     subtask_i,
  input  logic           freeze_i,
  input  logic [1:0]     access_i,
  input  logic [RBW-1:0] rbase_i,
  input  logic [MBW-1:0] mbase_i,
  output logic [RBW-1:0] rm_base_o,
  output logic [MBW-1:0] mem_base_o
);
  logic [ST_W-1:0] sub_q;
  logic            rb_merge_en;

  sbm_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (t0_i),
    .sub_i    (subtask_i),
    .sub_q_o  (sub_q)
  );

  sbm_rbase_path #(.RBW(RBW)) u_rb (
    .base_i     (rbase_i),
    .sub_i      (sub_q),
    .access_i   (access_i),
    .freeze_i   (freeze_i),
    .merge_en_o (rb_merge_en),
    .eff_o      (rm_base_o)
  );

  sbm_mbase_path #(.MBW(MBW)) u_mb (
    .base_i (mbase_i),
    .sub_i  (sub_q),
    .eff_o  (mem_base_o)
  );
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int RBW = 4,
  parameter int MBW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           t0_i,
  input logic [1:0]     subtask_i,
  input logic           freeze_i,
  input logic [1:0]     access_i,
  input logic [RBW-1:0] rbase_i,
  input logic [MBW-1:0] mbase_i,
  input logic [RBW-1:0] rm_base_o,
  input logic [MBW-1:0] mem_base_o,
  input logic [1:0]     sub_q,
  input logic           rb_merge_en
);
  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    t0_i |=> (sub_q == $past(subtask_i)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !t0_i |=> (sub_q == $past(sub_q)));

  // R3: the merge only ever sets bits, and the upper bits never move
  a_r3_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((rm_base_o & rbase_i) == rbase_i) && (rm_base_o[RBW-1:RBW-2] == rbase_i[RBW-1:RBW-2]));

  a_r4_readback_merged: assert property (@(posedge clk) disable iff (!rst_n)
    (access_i == 2'b01 && !freeze_i) |-> rb_merge_en);

  a_r5_chgwr_raw: assert property (@(posedge clk) disable iff (!rst_n)
    (access_i == 2'b10) |-> (rm_base_o == rbase_i));

  a_r6_freeze_raw: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |-> (rm_base_o == rbase_i));

  a_r7_mem_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_base_o & mbase_i) == mbase_i) && (mem_base_o[MBW-1:MBW-2] == mbase_i[MBW-1:MBW-2]));

  a_r8_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sub_q == 2'b00));
endmodule

bind subtask_base_merge sbm_checker #(.RBW(RBW), .MBW(MBW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .t0_i        (t0_i),
  .subtask_i   (subtask_i),
  .freeze_i    (freeze_i),
  .access_i    (access_i),
  .rbase_i     (rbase_i),
  .mbase_i     (mbase_i),
  .rm_base_o   (rm_base_o),
  .mem_base_o  (mem_base_o),
  .sub_q       (sub_q),
  .rb_merge_en (rb_merge_en)
);

// File: tb/subtask_base_merge_tb.sv
module subtask_base_merge_tb;
  localparam int RBW = 4;
  localparam int MBW = 5;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           t0_i = 0;
  logic [1:0]     subtask_i = 0;
  logic           freeze_i = 0;
  logic [1:0]     access_i = 0;
  logic [RBW-1:0] rbase_i = 0;
  logic [MBW-1:0] mbase_i = 0;
  logic [RBW-1:0] rm_base_o;
  logic [MBW-1:0] mem_base_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int sub_m = 0;

  always #2 clk = ~clk;

  subtask_base_merge #(.RBW(RBW), .MBW(MBW)) u_dut (
    .clk(clk), .rst_n(rst_n), .t0_i(t0_i), .subtask_i(subtask_i),
    .freeze_i(freeze_i), .access_i(access_i), .rbase_i(rbase_i),
    .mbase_i(mbase_i), .rm_base_o(rm_base_o), .mem_base_o(mem_base_o)
  );

  // reference: captured subtask
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_m = 0;
    else if (t0_i) sub_m = int'(subtask_i);
  end

  function automatic int exp_rm();
    int v = int'(rbase_i);
    if (access_i != 2'b10 && !freeze_i)
      v = v | (sub_m * (2 ** (RBW - 4)));
    return v;
  endfunction

  function automatic int exp_mem();
    return int'(mbase_i) | (sub_m * (2 ** (MBW - 4)));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string rm_tag();
    if (freeze_i) return "R6";
    if (access_i == 2'b10) return "R5";
    if (access_i == 2'b01) return "R4";
    return "R3";
  endfunction

  task automatic compare_all();
    chk(rm_tag(), int'(rm_base_o), exp_rm());
    chk("R7", int'(mem_base_o), exp_mem());
  endtask

  task automatic drive(input bit t0, input int st, input bit frz,
                       input int acc, input int rb, input int mb);
    t0_i = t0; subtask_i = 2'(st); freeze_i = frz;
    access_i = 2'(acc); rbase_i = RBW'(rb); mbase_i = MBW'(mb);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset state, subtask lines active but not captured
    drive(0, 3, 0, 0, 4'h8, 5'h10);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 rm", int'(rm_base_o), 8);
    chk("R8 mem", int'(mem_base_o), 16);

    // R1: capture 3
    drive(1, 3, 0, 0, 4'h8, 5'h10);
    @(negedge clk);
    chk("R1 rm", int'(rm_base_o), 8 | 3);
    chk("R1 mem", int'(mem_base_o), 16 | 6);

    // R2: lines change, strobe low, readback keeps old merge (R4)
    drive(0, 0, 0, 1, 4'h4, 5'h00);
    @(negedge clk);
    chk("R2 R4 rm", int'(rm_base_o), 4 | 3);
    chk("R2 mem", int'(mem_base_o), 6);

    // R5: change-base write raw, capture and write in same cycle
    drive(1, 1, 0, 2, 4'hC, 5'h11);
    @(negedge clk);
    chk("R5 rm", int'(rm_base_o), 12);
    chk("R7 mem after capture 1", int'(mem_base_o), 17 | 2);

    // R6: freeze with readback, new capture 2; memory still merges
    drive(1, 2, 1, 1, 4'h0, 5'h00);
    @(negedge clk);
    chk("R6 rm", int'(rm_base_o), 0);
    chk("R7 mem under freeze", int'(mem_base_o), 4);

    // R9: subtask 2 (bit 0 clear): low bits follow inputs
    drive(0, 0, 0, 0, 4'h1, 5'h01);
    @(negedge clk);
    chk("R9 rm", int'(rm_base_o), 1 | 2);
    chk("R9 mem", int'(mem_base_o), 1 | 4);
    drive(0, 0, 0, 3, 4'h0, 5'h00);
    @(negedge clk);
    chk("R9 R3 rm", int'(rm_base_o), 2);
    chk("R9 mem", int'(mem_base_o), 4);

    // random traffic compared every cycle
    for (int i = 0; i < 3000; i++) begin
      drive(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
            ($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 15)), int'($urandom_range(0, 31)));
      @(negedge clk);
      compare_all();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule